// File: doc/BRIEF.md
# UART FIFO Interrupt and Line Status Unit

This unit watches one UART channel's 16-entry receive and transmit byte queues. It keeps its own occupancy counts, driven by the push and pop strobes the queues see. It also keeps a shadow copy of the 4-bit error tag that goes with every received byte. From this state it builds the 8-bit line status byte, the receive-data and transmit-empty interrupt requests, a combined interrupt line, and the 4-bit interrupt identification code that the host reads.

The receive-data request follows the selected trigger level in both directions: it is high while occupancy is at or above the level, and low below it. The transmit-empty request is a sticky flag. A pop that drains the transmit queue sets it. A holding-register write clears it, and so does an identification read that returns the transmit-empty code. With all enables low, no interrupt is raised and the host polls the status byte. All state uses a synchronous active-high reset. Outputs depend only on registered state and on the static configuration inputs.

Top module: `uart_irq_status`

## Requirements
- R1: The receive count rises on `rx_push` and falls on `rx_pop`. It holds at most 16, and a pop on an empty queue or a push into a full queue (without a pop in the same cycle) is ignored. `lsr[0]` is 1 exactly when the count is nonzero. The result is visible right after the clock edge that accepts the strobe.
- R2: `lsr[4:1]` equals the error tag pushed with the byte now at the receive head, and is 0 when the queue is empty. Tag bit 0 is overrun, bit 1 parity, bit 2 framing and bit 3 break.
- R3: `lsr[7]` is 1 while any byte held in the receive queue has a nonzero tag.
- R4: `lsr[5]` is 1 when the transmit count is zero. `lsr[6]` is 1 when the transmit count is zero and `tx_shift_idle` is 1.
- R5: With `ier[0]`=1, `rx_data_req` is 1 while the receive count is at least the trigger level, and 0 below it. `rx_trig_sel` values 0, 1, 2 and 3 select levels 1, 4, 8 and 14. With `fifo_en`=0 the level is 1.
- R6: A `tx_pop` that empties the transmit queue, with no `tx_push` or `tx_fifo_clr` in the same cycle and with `ier[1]`=1, sets the transmit-empty flag. Any `tx_push` clears the flag. So does an `iir_rd` while `iir` reads 4'b0010. `tx_empty_req` is the flag gated by `ier[1]`.
- R7: With `ier[2]`=1, a receive line status interrupt is pending while the head byte has a nonzero tag.
- R8: `iir` reads 4'b0110 for line status, 4'b0100 for receive data and 4'b0010 for transmit empty, in that order of priority, and 4'b0001 when none is pending. `irq` is 1 whenever any of these is pending.
- R9: With `ier` all zero, `irq` stays 0 and `iir` reads 4'b0001, while `lsr` keeps tracking the queues.
- R10: `rx_fifo_clr` or `tx_fifo_clr` empties the matching count, and clears the error tags, on that same edge. It overrides a push in that cycle, so `lsr[0]` and `lsr[7]` go to 0 and `lsr[5]` goes to 1.
- R11: After reset both counts are zero, the transmit flag is clear, `irq` is 0, `iir` is 4'b0001 and `lsr` is {1'b0, tx_shift_idle, 1'b1, 5'b0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queue mode enable; when 0 the trigger level is 1 |
| rx_trig_sel | input | 2 | Receive trigger level select |
| ier | input | 3 | Enables: [0] receive data, [1] transmit empty, [2] line status |
| rx_push | input | 1 | A received byte enters the receive queue |
| rx_push_err | input | 4 | Error tag of that byte |
| rx_pop | input | 1 | Host reads a byte from the receive queue |
| rx_fifo_clr | input | 1 | Receive queue reset |
| tx_push | input | 1 | Host writes the holding register |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_fifo_clr | input | 1 | Transmit queue reset |
| tx_shift_idle | input | 1 | Transmit shift register is empty |
| iir_rd | input | 1 | Host reads the identification register |
| lsr | output | 8 | Line status byte |
| iir | output | 4 | Interrupt identification code |
| irq | output | 1 | Combined interrupt request |
| rx_data_req | output | 1 | Receive-data request |
| tx_empty_req | output | 1 | Transmit-empty request |

## Verification
The bench builds the unit with its default depth of 16 and trigger levels of 1, 4, 8 and 14. All four levels, a full queue and the overflow push are then reached within a few dozen cycles. Because the depth is not shrunk, the 14-byte level and the ignored seventeenth push are both exercised. The read-clear rule for the transmit flag is covered while a higher-priority source is showing and again once it is not.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IID_NONE    = 4'b0001,
    IID_TXEMPTY = 4'b0010,
    IID_RXDATA  = 4'b0100,
    IID_LINE    = 4'b0110
  } iid_e;

  localparam int ERR_TAG_W = 4;
endpackage

// File: rtl/uart_occ_cnt.sv
`timescale 1ns/1ps
module uart_occ_cnt #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count
);
  logic pop_ok, push_ok;

  assign pop_ok  = pop & (count != '0);
  assign push_ok = push & ((count != CNT_W'(DEPTH)) | pop_ok);

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (push_ok && !pop_ok)
      count <= count + 1'b1;
    else if (pop_ok && !push_ok)
      count <= count - 1'b1;
  end

  p_count_max_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_clear_empties_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
endmodule

// File: rtl/uart_rx_tag_track.sv
`timescale 1ns/1ps
module uart_rx_tag_track #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             pop,
  input  logic [CNT_W-1:0] count,
  output logic [TAG_W-1:0] head_tag,
  output logic             any_err
);
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] err_cnt;
  logic             pop_ok, push_ok, inc, dec;
  logic [TAG_W-1:0] raw_head;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok   = pop & (count != '0);
  assign push_ok  = push & ((count != CNT_W'(DEPTH)) | pop_ok);
  assign raw_head = tag_mem[rd_ptr];
  assign inc      = push_ok & (|push_tag);
  assign dec      = pop_ok & (|raw_head);

  // Tag storage: plain write port, no reset, so it maps onto RAM cells.
  always_ff @(posedge clk) begin
    if (push_ok && !clr)
      tag_mem[wr_ptr] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      err_cnt <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      if (inc && !dec)      err_cnt <= err_cnt + 1'b1;
      else if (dec && !inc) err_cnt <= err_cnt - 1'b1;
    end
  end

  assign head_tag = (count != '0) ? raw_head : '0;
  assign any_err  = (err_cnt != '0);

  p_err_within_count_r3: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= count);

  p_head_tag_empty_r2: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (head_tag == '0) && !any_err);
endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [2:0]       ier,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_head_bad,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic             tx_clr,
  input  logic             iir_rd,
  output logic             line_req,
  output logic             rx_data_req,
  output logic             tx_empty_req,
  output logic             irq,
  output logic [3:0]       iir
);
  logic [CNT_W-1:0] lvl;
  logic             tx_drain, tx_flag;
  iid_e             iid;

  always_comb begin
    if (!fifo_en) lvl = CNT_W'(1);
    else begin
      case (trig_sel)
        2'd0:    lvl = CNT_W'(TRIG0);
        2'd1:    lvl = CNT_W'(TRIG1);
        2'd2:    lvl = CNT_W'(TRIG2);
        default: lvl = CNT_W'(TRIG3);
      endcase
    end
  end

  assign rx_data_req = ier[0] & (rx_count >= lvl);
  assign line_req    = ier[2] & rx_head_bad;
  assign tx_drain    = tx_pop & (tx_count == CNT_W'(1)) & ~tx_push & ~tx_clr;

  always_ff @(posedge clk) begin
    if (rst)
      tx_flag <= 1'b0;
    else if (tx_drain && ier[1])
      tx_flag <= 1'b1;
    else if (tx_push || (iir_rd && iid == IID_TXEMPTY))
      tx_flag <= 1'b0;
  end

  assign tx_empty_req = tx_flag & ier[1];

  always_comb begin
    if (line_req)          iid = IID_LINE;
    else if (rx_data_req)  iid = IID_RXDATA;
    else if (tx_empty_req) iid = IID_TXEMPTY;
    else                   iid = IID_NONE;
  end

  assign iir = iid;
  assign irq = line_req | rx_data_req | tx_empty_req;

  p_iir_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (iir == 4'b0001));

  p_polled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (ier == 3'b000) |-> !irq);

  p_thr_wr_clears_r6: assert property (@(posedge clk) disable iff (rst)
    tx_push |=> !tx_empty_req);

  p_trig_rise_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_data_req) && $stable(ier) && $stable(fifo_en) && $stable(trig_sel))
      |-> (rx_count == lvl));
endmodule

// File: rtl/uart_irq_status.sv
`timescale 1ns/1ps
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fifo_en,
  input  logic [1:0]           rx_trig_sel,
  input  logic [2:0]           ier,
  input  logic                 rx_push,
  input  logic [ERR_TAG_W-1:0] rx_push_err,
  input  logic                 rx_pop,
  input  logic                 rx_fifo_clr,
  input  logic                 tx_push,
  input  logic                 tx_pop,
  input  logic                 tx_fifo_clr,
  input  logic                 tx_shift_idle,
  input  logic                 iir_rd,
  output logic [7:0]           lsr,
  output logic [3:0]           iir,
  output logic                 irq,
  output logic                 rx_data_req,
  output logic                 tx_empty_req
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]     rx_count, tx_count;
  logic [ERR_TAG_W-1:0] rx_head_tag;
  logic                 rx_any_err, line_req, tx_empty;

  uart_occ_cnt #(.DEPTH(DEPTH)) u_rx_cnt (
    .clk(clk), .rst(rst), .clr(rx_fifo_clr),
    .push(rx_push), .pop(rx_pop), .count(rx_count)
  );

  uart_occ_cnt #(.DEPTH(DEPTH)) u_tx_cnt (
    .clk(clk), .rst(rst), .clr(tx_fifo_clr),
    .push(tx_push), .pop(tx_pop), .count(tx_count)
  );

  uart_rx_tag_track #(.DEPTH(DEPTH), .TAG_W(ERR_TAG_W)) u_rx_tags (
    .clk(clk), .rst(rst), .clr(rx_fifo_clr),
    .push(rx_push), .push_tag(rx_push_err), .pop(rx_pop),
    .count(rx_count), .head_tag(rx_head_tag), .any_err(rx_any_err)
  );

  uart_irq_ctrl #(
    .DEPTH(DEPTH), .TRIG0(TRIG0), .TRIG1(TRIG1), .TRIG2(TRIG2), .TRIG3(TRIG3)
  ) u_irq (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(rx_trig_sel), .ier(ier),
    .rx_count(rx_count), .rx_head_bad(|rx_head_tag), .tx_count(tx_count),
    .tx_push(tx_push), .tx_pop(tx_pop), .tx_clr(tx_fifo_clr), .iir_rd(iir_rd),
    .line_req(line_req), .rx_data_req(rx_data_req), .tx_empty_req(tx_empty_req),
    .irq(irq), .iir(iir)
  );

  assign tx_empty = (tx_count == '0);
  assign lsr = {rx_any_err, tx_empty & tx_shift_idle, tx_empty,
                rx_head_tag, rx_count != '0};

  p_line_first_r7: assert property (@(posedge clk) disable iff (rst)
    line_req |-> (iir == 4'b0110) && irq);

  p_clr_status_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_fifo_clr && tx_fifo_clr) |=> (lsr[0] == 1'b0) && (lsr[7] == 1'b0) && lsr[5]);
endmodule

// File: tb/test_uart_irq_status.sv
`timescale 1ns/1ps
module test_uart_irq_status;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, fifo_en = 1'b1, tx_shift_idle = 1'b1;
  logic [1:0] rx_trig_sel = '0;
  logic [2:0] ier = '0;
  logic rx_push = 0, rx_pop = 0, rx_fifo_clr = 0, tx_push = 0, tx_pop = 0;
  logic tx_fifo_clr = 0, iir_rd = 0;
  logic [3:0] rx_push_err = '0;
  logic [7:0] lsr;
  logic [3:0] iir;
  logic irq, rx_data_req, tx_empty_req;

  uart_irq_status i_uart_irq_status (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_trig_sel(rx_trig_sel), .ier(ier),
    .rx_push(rx_push), .rx_push_err(rx_push_err), .rx_pop(rx_pop),
    .rx_fifo_clr(rx_fifo_clr), .tx_push(tx_push), .tx_pop(tx_pop),
    .tx_fifo_clr(tx_fifo_clr), .tx_shift_idle(tx_shift_idle), .iir_rd(iir_rd),
    .lsr(lsr), .iir(iir), .irq(irq), .rx_data_req(rx_data_req),
    .tx_empty_req(tx_empty_req)
  );

  typedef struct {
    logic [7:0] lsr; logic [3:0] iir; logic irq; logic rxr; logic txr; string tag;
  } exp_t;
  exp_t sb[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // configuration applied by step at its drive point
  bit c_fifo_en = 1, c_idle = 1;
  logic [1:0] c_sel = 0;
  logic [2:0] c_ier = 0;

  // reference model
  logic [3:0] mq[$];
  int mtx = 0;
  bit mflag = 0;

  function automatic int m_lvl();
    if (!c_fifo_en) return 1;
    case (c_sel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic bit m_line(); return c_ier[2] && mq.size() > 0 && mq[0] != 0; endfunction
  function automatic bit m_rxd();  return c_ier[0] && mq.size() >= m_lvl(); endfunction
  function automatic bit m_tx();   return c_ier[1] && mflag; endfunction

  function automatic logic [3:0] m_iir();
    if (m_line()) return 4'b0110;
    if (m_rxd())  return 4'b0100;
    if (m_tx())   return 4'b0010;
    return 4'b0001;
  endfunction

  function automatic logic [7:0] m_lsr();
    logic [7:0] v;
    bit any;
    any = 0;
    foreach (mq[i]) if (mq[i] != 0) any = 1;
    v[0] = mq.size() > 0;
    v[4:1] = (mq.size() > 0) ? mq[0] : 4'h0;
    v[5] = (mtx == 0);
    v[6] = (mtx == 0) && c_idle;
    v[7] = any;
    return v;
  endfunction

  task automatic step(input bit rp, input logic [3:0] rt, input bit rpop, input bit tp,
                      input bit tpop, input bit rd, input bit rclr, input bit tclr,
                      input string tag);
    logic [3:0] cur;
    bit pok, tpok, drain;
    @(negedge clk);
    fifo_en = c_fifo_en; rx_trig_sel = c_sel; ier = c_ier; tx_shift_idle = c_idle;
    rx_push = rp; rx_push_err = rt; rx_pop = rpop; tx_push = tp; tx_pop = tpop;
    iir_rd = rd; rx_fifo_clr = rclr; tx_fifo_clr = tclr;
    cur = m_iir();
    if (rclr) mq.delete();
    else begin
      pok = rpop && mq.size() > 0;
      if (pok) void'(mq.pop_front());
      if (rp && mq.size() < DEPTH) mq.push_back(rt);
    end
    tpok = tpop && mtx > 0;
    drain = tpok && mtx == 1 && !tp && !tclr;
    if (tclr) mtx = 0;
    else begin
      if (tpok) mtx--;
      if (tp && mtx < DEPTH) mtx++;
    end
    if (drain && c_ier[1]) mflag = 1;
    else if (tp || (rd && cur == 4'b0010)) mflag = 0;
    sb.push_back('{m_lsr(), m_iir(), m_iir() != 4'b0001, m_rxd(), m_tx(), tag});
    @(posedge clk);
  endtask

  task automatic idle(input string t);              step(0, 0, 0, 0, 0, 0, 0, 0, t); endtask
  task automatic rxin(input logic [3:0] e, input string t); step(1, e, 0, 0, 0, 0, 0, 0, t); endtask
  task automatic rxout(input string t);             step(0, 0, 1, 0, 0, 0, 0, 0, t); endtask
  task automatic txin(input string t);              step(0, 0, 0, 1, 0, 0, 0, 0, t); endtask
  task automatic txout(input string t);             step(0, 0, 0, 0, 1, 0, 0, 0, t); endtask
  task automatic rdiir(input string t);             step(0, 0, 0, 0, 0, 1, 0, 0, t); endtask
  task automatic clrall(input string t);            step(0, 0, 0, 0, 0, 0, 1, 1, t); endtask

  // monitor: compares each queued expectation a little after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if (lsr !== e.lsr || iir !== e.iir || irq !== e.irq ||
            rx_data_req !== e.rxr || tx_empty_req !== e.txr) begin
          n_fail++;
          $display("FAIL %s: lsr=%h iir=%b irq=%b rxr=%b txr=%b expected lsr=%h iir=%b irq=%b rxr=%b txr=%b",
                   e.tag, lsr, iir, irq, rx_data_req, tx_empty_req,
                   e.lsr, e.iir, e.irq, e.rxr, e.txr);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    n_run++;
    if (lsr !== 8'h60 || iir !== 4'b0001 || irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: lsr=%h iir=%b irq=%b expected lsr=60 iir=0001 irq=0", lsr, iir, irq);
    end

    // R1: counting, full queue, empty pops
    for (int i = 0; i < 3; i++) rxin(0, "R1");
    for (int i = 0; i < 3; i++) rxout("R1");
    rxout("R1");
    for (int i = 0; i < 17; i++) rxin(0, "R1");
    for (int i = 0; i < 16; i++) rxout("R1");
    idle("R1");

    // R2, R3: head tags and any-error flag
    rxin(4'b0001, "R2");
    rxin(4'b0000, "R3");
    rxin(4'b0010, "R2");
    rxin(4'b1000, "R2");
    for (int i = 0; i < 4; i++) rxout("R3");

    // R4: transmit empty and shifter idle
    c_idle = 0;
    txin("R4"); txin("R4");
    txout("R4"); txout("R4");
    c_idle = 1;
    idle("R4");

    // R5: trigger levels, rise and fall
    c_ier = 3'b001;
    for (int s = 0; s < 4; s++) begin
      c_sel = 2'(s);
      for (int k = 0; k < m_lvl() + 1; k++) rxin(0, "R5");
      rxout("R5");
      rxout("R5");
      clrall("R10");
    end
    c_fifo_en = 0; c_sel = 2'd3;
    rxin(0, "R5");
    rxout("R5");
    c_fifo_en = 1;

    // R6: transmit-empty flag set and clear paths
    c_ier = 3'b010;
    txin("R6"); txout("R6");
    txin("R6"); txout("R6");
    rdiir("R6");
    idle("R6");
    txin("R6");
    c_ier = 3'b000;
    txout("R6");
    c_ier = 3'b010;
    idle("R6");

    // R7, R8: priority between sources
    c_ier = 3'b111; c_sel = 2'd1;
    txin("R8"); txout("R8");
    for (int i = 0; i < 4; i++) rxin(0, "R8");
    rxin(4'b0100, "R7");
    rdiir("R8");
    for (int i = 0; i < 4; i++) rxout("R7");
    rxout("R8");
    rdiir("R8");
    idle("R8");

    // R9: polled operation
    c_ier = 3'b000;
    for (int i = 0; i < 14; i++) rxin(4'(i % 3), "R9");
    txin("R9"); txout("R9");

    // R10: reset of both queues overrides a push in the same cycle
    txin("R10");
    step(1, 4'b0010, 0, 1, 0, 0, 1, 1, "R10");
    idle("R10");

    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule